// File: doc/BRIEF.md
# Two-Wire Master Command Register Bank

This block is the software-facing register bank of a two-wire (I2C-style) bus master. A processor reaches it through a simple 32-bit, word-addressed write port and a combinational read port. The bank holds the clock divider and glitch filter settings, the bus configuration, the slave address and up to eight bytes of data. It passes all of these to a separate bit-level bus engine, which is not part of this block.

A single write to the command register launches a whole packed transaction. The command word carries the type (write, read, or write then read) and both byte counts. The bank raises a one-cycle start strobe and holds a busy flag until the engine reports completion. On completion, a done flag and any error causes are latched into one status word, and the data registers capture the bytes the engine read. A ranked result code is also recorded. Software clears status flags by writing ones back to them. An interrupt line is raised for every set status bit that is enabled in the mask.

Top module: `twi_rb_top`

## Requirements
- R1: After reset, both clock words read 0x0000301F (filter 3 in bits 15:12, divider 0x01F in bits 9:0), configuration reads 0x00003302, and command, slave address, both data words, status, mask and busy read 0; irq and eng_start are low.
- R2: Word indices map to registers as follows: 0 standard clock, 1 high-speed clock, 2 configuration, 3 command, 4 slave address, 5 data low, 6 data high, 7 status, 8 mask, 9 busy; byte offset is four times the index. Only implemented bits store: clock words keep mask 0xF3FF, configuration keeps 0xFFF3 (bits 15:12 arbitration filter, 11:8 NAK retries, 7 ten-bit address, 6:4 master code, 1 arbitration enable, 0 high speed), slave address keeps 10 bits, data words keep 32 bits.
- R3: A command write while idle stores bits 9:8 as type (0 write, 1 read, 2 write-then-read), 6:4 as write length minus one and 2:0 as read length minus one (readback mask 0x377). On the next cycle eng_start is high for exactly one cycle and busy reads 1.
- R4: A command write while busy is 1 is ignored: no start strobe follows and the command register and eng_type keep their values.
- R5: eng_done while busy clears busy in the next cycle and sets status bit 0 (done) regardless of outcome, plus bit 1 for eng_err[0] (lost arbitration), bit 2 for eng_err[1] (no response), bit 3 for eng_err[2] (data collision) and bit 4 for eng_err[3] (bus busy).
- R6: Writing the status word clears exactly the bits written as one; a flag set by the engine in the same cycle as its clear stays set.
- R7: irq is high exactly when some status bit is set and the same mask bit is set; the mask is 5 bits and resets to zero.
- R8: A completion of a read or write-then-read command loads eng_rdata[31:0] into data low and eng_rdata[63:32] into data high; a write-only completion leaves both data words unchanged.
- R9: On each completion eng_result records a ranked code: 1 if lost arbitration, else 2 if no response, else 3 if data collision, else 4 if bus busy, else 0 for success.
- R10: eng_done while busy is 0 is ignored: status, data words, busy and eng_result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word index of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the indexed register |
| irq | output | 1 | Interrupt request |
| eng_start | output | 1 | One-cycle launch strobe to the engine |
| eng_type | output | 2 | Command type |
| eng_wr_len | output | 3 | Write byte count minus one |
| eng_rd_len | output | 3 | Read byte count minus one |
| eng_slave | output | 10 | Slave address |
| eng_wdata | output | 64 | Outgoing data, data high above data low |
| eng_clk_std | output | 16 | Standard clock word |
| eng_clk_hs | output | 16 | High-speed clock word |
| eng_cfg | output | 16 | Bus configuration word |
| eng_done | input | 1 | Engine completion pulse |
| eng_err | input | 4 | Error causes valid with eng_done |
| eng_rdata | input | 64 | Bytes read by the engine, valid with eng_done |
| eng_result | output | 3 | Ranked result of the last completion |

## Verification
A busy flag stuck high shows up at once as a missing start strobe on the next launch. A busy flag stuck low lets a second command write retrigger the engine one cycle later. A wrong clear-versus-set ordering in the status word loses a done flag in the collision cycle, so irq stays low where it should rise on the following cycle. Errors in capture or ranking show up at the first read of the data words, or as a wrong eng_result one cycle after completion. The stray-completion and write-only cases confirm, through readback, that nothing moved.

// File: rtl/twi_rb_pkg.sv
package twi_rb_pkg;
  localparam int WORD_W   = 32;
  localparam int IDX_W    = 4;
  localparam int STS_W    = 5;
  localparam int ERR_W    = STS_W - 1;
  localparam int CTRL_W   = 16;

  localparam logic [IDX_W-1:0] IX_CLK_STD = 4'd0;
  localparam logic [IDX_W-1:0] IX_CLK_HS  = 4'd1;
  localparam logic [IDX_W-1:0] IX_CFG     = 4'd2;
  localparam logic [IDX_W-1:0] IX_CMD     = 4'd3;
  localparam logic [IDX_W-1:0] IX_SLAVE   = 4'd4;
  localparam logic [IDX_W-1:0] IX_DLO     = 4'd5;
  localparam logic [IDX_W-1:0] IX_DHI     = 4'd6;
  localparam logic [IDX_W-1:0] IX_STS     = 4'd7;
  localparam logic [IDX_W-1:0] IX_MASK    = 4'd8;
  localparam logic [IDX_W-1:0] IX_BUSY    = 4'd9;

  typedef enum logic [1:0] {
    CT_WRITE = 2'd0,
    CT_READ  = 2'd1,
    CT_WR_RD = 2'd2,
    CT_RSVD  = 2'd3
  } cmd_type_e;

  typedef enum logic [2:0] {
    RS_OK     = 3'd0,
    RS_ARB    = 3'd1,
    RS_NORESP = 3'd2,
    RS_COLL   = 3'd3,
    RS_BUSY   = 3'd4
  } result_e;
endpackage

// File: rtl/twi_rb_cfg.sv
module twi_rb_cfg #(
  parameter int FILT_W = 4,
  parameter int DIV_W  = 10,
  parameter int N_CLK  = 2
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [N_CLK-1:0]                  clk_we,
  input  logic                              cfg_we,
  input  logic [twi_rb_pkg::CTRL_W-1:0]     wdata,
  output logic [N_CLK-1:0][twi_rb_pkg::CTRL_W-1:0] clk_q,
  output logic [twi_rb_pkg::CTRL_W-1:0]     cfg_q
);
  import twi_rb_pkg::*;

  localparam logic [CTRL_W-1:0] FILT_FIELD = CTRL_W'(((1 << FILT_W) - 1) << (CTRL_W - FILT_W));
  localparam logic [CTRL_W-1:0] DIV_FIELD  = CTRL_W'((1 << DIV_W) - 1);
  localparam logic [CTRL_W-1:0] CLK_KEEP   = FILT_FIELD | DIV_FIELD;
  localparam logic [CTRL_W-1:0] CLK_RST    = CTRL_W'((3 << (CTRL_W - FILT_W)) | 16'h001F);
  localparam logic [CTRL_W-1:0] CFG_KEEP   = 16'hFFF3;
  localparam logic [CTRL_W-1:0] CFG_RST    = 16'h3302;

  logic [CTRL_W-1:0] cfg_d;

  for (genvar g = 0; g < N_CLK; g++) begin : g_clkreg
    logic [CTRL_W-1:0] clk_d;
    always_comb begin
      clk_d = wdata & CLK_KEEP;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         clk_q[g] <= CLK_RST;
      else if (clk_we[g]) clk_q[g] <= clk_d;
    end
  end

  always_comb begin
    cfg_d = wdata & CFG_KEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= CFG_RST;
    else if (cfg_we) cfg_q <= cfg_d;
  end

  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(cfg_q));
  p_cfg_unused_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (cfg_q[3:2] == 2'b00));
endmodule

// File: rtl/twi_rb_launch.sv
module twi_rb_launch #(
  parameter int SLV_W  = 10,
  parameter int DATA_W = 64
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_we,
  input  logic                          slv_we,
  input  logic                          dlo_we,
  input  logic                          dhi_we,
  input  logic [twi_rb_pkg::WORD_W-1:0] wdata,
  input  logic                          eng_done,
  input  logic [DATA_W-1:0]             eng_rdata,
  output logic                          busy,
  output logic                          eng_start,
  output logic [twi_rb_pkg::CTRL_W-1:0] cmd_q,
  output logic [SLV_W-1:0]              slave_q,
  output logic [DATA_W-1:0]             data_q,
  output logic                          done_ok
);
  import twi_rb_pkg::*;

  localparam int HALF_W = DATA_W / 2;
  localparam logic [CTRL_W-1:0] CMD_KEEP = 16'h0377;

  logic                cmd_ok;
  logic                capture;
  logic                busy_d;
  logic [CTRL_W-1:0]   cmd_d;
  logic [SLV_W-1:0]    slave_d;
  logic [DATA_W-1:0]   data_d;
  logic                data_en;
  cmd_type_e           cur_type;

  always_comb begin
    cur_type = cmd_type_e'(cmd_q[9:8]);
    cmd_ok   = cmd_we & ~busy;
    done_ok  = eng_done & busy;
    capture  = done_ok & ((cur_type == CT_READ) | (cur_type == CT_WR_RD));
    cmd_d    = wdata[CTRL_W-1:0] & CMD_KEEP;
    slave_d  = wdata[SLV_W-1:0];
  end

  always_comb begin
    busy_d = busy;
    if (cmd_ok)       busy_d = 1'b1;
    else if (done_ok) busy_d = 1'b0;
  end

  always_comb begin
    data_d  = data_q;
    data_en = capture | dlo_we | dhi_we;
    if (capture) begin
      data_d = eng_rdata;
    end else begin
      if (dlo_we) data_d[HALF_W-1:0]      = wdata[HALF_W-1:0];
      if (dhi_we) data_d[DATA_W-1:HALF_W] = wdata[HALF_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      eng_start <= 1'b0;
    end else begin
      busy      <= busy_d;
      eng_start <= cmd_ok;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (cmd_ok) cmd_q <= cmd_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      slave_q <= '0;
    else if (slv_we) slave_q <= slave_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  p_start_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && !busy |=> eng_start && busy);
  p_start_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);
  p_ignore_cmd_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && busy |=> !eng_start && $stable(cmd_q));
  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && busy |=> !busy);
  p_stray_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done && !busy && !cmd_we && !dlo_we && !dhi_we |=> !busy && $stable(data_q));
endmodule

// File: rtl/twi_rb_status.sv
module twi_rb_status (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               clr_we,
  input  logic                               mask_we,
  input  logic [twi_rb_pkg::STS_W-1:0]       wdata,
  input  logic                               set_v,
  input  logic [twi_rb_pkg::ERR_W-1:0]       set_err,
  output logic [twi_rb_pkg::STS_W-1:0]       sts_q,
  output logic [twi_rb_pkg::STS_W-1:0]       mask_q,
  output logic                               irq,
  output logic [2:0]                         result_q
);
  import twi_rb_pkg::*;

  logic [STS_W-1:0] set_bits;
  logic [STS_W-1:0] clr_bits;
  logic [STS_W-1:0] sts_d;
  result_e          result_d;

  always_comb begin
    set_bits = set_v  ? {set_err, 1'b1} : '0;
    clr_bits = clr_we ? wdata           : '0;
    sts_d    = (sts_q & ~clr_bits) | set_bits;
    irq      = |(sts_q & mask_q);
  end

  always_comb begin
    if (set_err[0])      result_d = RS_ARB;
    else if (set_err[1]) result_d = RS_NORESP;
    else if (set_err[2]) result_d = RS_COLL;
    else if (set_err[3]) result_d = RS_BUSY;
    else                 result_d = RS_OK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sts_q <= '0;
    else        sts_q <= sts_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_we) mask_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     result_q <= 3'(RS_OK);
    else if (set_v) result_q <= 3'(result_d);
  end

  p_done_latch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    set_v |=> sts_q[0]);
  p_w1c_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we && !set_v |=> ((sts_q & $past(wdata)) == '0));
  p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set_v && mask_q[0] && !mask_we |=> irq);
  p_rank_arb_r9: assert property (@(posedge clk) disable iff (!rst_n)
    set_v && set_err[0] |=> result_q == 3'(RS_ARB));
endmodule

// File: rtl/twi_rb_top.sv
module twi_rb_top #(
  parameter int SLV_W  = 10,
  parameter int DATA_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [3:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               irq,
  output logic               eng_start,
  output logic [1:0]         eng_type,
  output logic [2:0]         eng_wr_len,
  output logic [2:0]         eng_rd_len,
  output logic [SLV_W-1:0]   eng_slave,
  output logic [DATA_W-1:0]  eng_wdata,
  output logic [15:0]        eng_clk_std,
  output logic [15:0]        eng_clk_hs,
  output logic [15:0]        eng_cfg,
  input  logic               eng_done,
  input  logic [3:0]         eng_err,
  input  logic [DATA_W-1:0]  eng_rdata,
  output logic [2:0]         eng_result
);
  import twi_rb_pkg::*;

  localparam int HALF_W = DATA_W / 2;

  logic [1:0]              clk_we;
  logic                    cfg_we, cmd_we, slv_we, dlo_we, dhi_we, sts_we, mask_we;
  logic [1:0][CTRL_W-1:0]  clk_words;
  logic [CTRL_W-1:0]       cfg_word;
  logic [CTRL_W-1:0]       cmd_word;
  logic [SLV_W-1:0]        slave_word;
  logic [DATA_W-1:0]       data_word;
  logic [STS_W-1:0]        sts_word;
  logic [STS_W-1:0]        mask_word;
  logic                    busy;
  logic                    done_ok;

  always_comb begin
    clk_we[0] = bus_we & (bus_addr == IX_CLK_STD);
    clk_we[1] = bus_we & (bus_addr == IX_CLK_HS);
    cfg_we    = bus_we & (bus_addr == IX_CFG);
    cmd_we    = bus_we & (bus_addr == IX_CMD);
    slv_we    = bus_we & (bus_addr == IX_SLAVE);
    dlo_we    = bus_we & (bus_addr == IX_DLO);
    dhi_we    = bus_we & (bus_addr == IX_DHI);
    sts_we    = bus_we & (bus_addr == IX_STS);
    mask_we   = bus_we & (bus_addr == IX_MASK);
  end

  twi_rb_cfg #(.FILT_W(4), .DIV_W(10), .N_CLK(2)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .clk_we (clk_we),
    .cfg_we (cfg_we),
    .wdata  (bus_wdata[CTRL_W-1:0]),
    .clk_q  (clk_words),
    .cfg_q  (cfg_word)
  );

  twi_rb_launch #(.SLV_W(SLV_W), .DATA_W(DATA_W)) u_launch (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_we    (cmd_we),
    .slv_we    (slv_we),
    .dlo_we    (dlo_we),
    .dhi_we    (dhi_we),
    .wdata     (bus_wdata),
    .eng_done  (eng_done),
    .eng_rdata (eng_rdata),
    .busy      (busy),
    .eng_start (eng_start),
    .cmd_q     (cmd_word),
    .slave_q   (slave_word),
    .data_q    (data_word),
    .done_ok   (done_ok)
  );

  twi_rb_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_we   (sts_we),
    .mask_we  (mask_we),
    .wdata    (bus_wdata[STS_W-1:0]),
    .set_v    (done_ok),
    .set_err  (eng_err),
    .sts_q    (sts_word),
    .mask_q   (mask_word),
    .irq      (irq),
    .result_q (eng_result)
  );

  always_comb begin
    eng_type    = cmd_word[9:8];
    eng_wr_len  = cmd_word[6:4];
    eng_rd_len  = cmd_word[2:0];
    eng_slave   = slave_word;
    eng_wdata   = data_word;
    eng_clk_std = clk_words[0];
    eng_clk_hs  = clk_words[1];
    eng_cfg     = cfg_word;
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      IX_CLK_STD: bus_rdata = {16'h0, clk_words[0]};
      IX_CLK_HS:  bus_rdata = {16'h0, clk_words[1]};
      IX_CFG:     bus_rdata = {16'h0, cfg_word};
      IX_CMD:     bus_rdata = {16'h0, cmd_word};
      IX_SLAVE:   bus_rdata = WORD_W'(slave_word);
      IX_DLO:     bus_rdata = data_word[HALF_W-1:0];
      IX_DHI:     bus_rdata = data_word[DATA_W-1:HALF_W];
      IX_STS:     bus_rdata = WORD_W'(sts_word);
      IX_MASK:    bus_rdata = WORD_W'(mask_word);
      IX_BUSY:    bus_rdata = WORD_W'(busy);
      default:    bus_rdata = '0;
    endcase
  end

  p_busy_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> busy);
endmodule

// File: tb/tb_twi_rb_top.sv
module tb_twi_rb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_we;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq;
  logic        eng_start;
  logic [1:0]  eng_type;
  logic [2:0]  eng_wr_len, eng_rd_len;
  logic [9:0]  eng_slave;
  logic [63:0] eng_wdata;
  logic [15:0] eng_clk_std, eng_clk_hs, eng_cfg;
  logic        eng_done;
  logic [3:0]  eng_err;
  logic [63:0] eng_rdata;
  logic [2:0]  eng_result;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  twi_rb_top dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq),
    .eng_start(eng_start), .eng_type(eng_type), .eng_wr_len(eng_wr_len),
    .eng_rd_len(eng_rd_len), .eng_slave(eng_slave), .eng_wdata(eng_wdata),
    .eng_clk_std(eng_clk_std), .eng_clk_hs(eng_clk_hs), .eng_cfg(eng_cfg),
    .eng_done(eng_done), .eng_err(eng_err), .eng_rdata(eng_rdata),
    .eng_result(eng_result)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic done_pulse(input logic [3:0] e, input logic [63:0] r);
    @(negedge clk);
    eng_done = 1'b1; eng_err = e; eng_rdata = r;
    @(negedge clk);
    eng_done = 1'b0; eng_err = '0;
  endtask

  task automatic launch_and_finish(input logic [31:0] c, input logic [3:0] e, input logic [63:0] r);
    wr(4'd3, c);
    done_pulse(e, r);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(4'd0, v); chk("R1 std clock", v, 32'h301F);
    rd(4'd1, v); chk("R1 hs clock", v, 32'h301F);
    rd(4'd2, v); chk("R1 cfg", v, 32'h3302);
    for (int i = 3; i <= 9; i++) begin
      rd(4'(i), v); chk("R1 zero word", v, 0);
    end
    chk("R1 irq", irq, 0);
    chk("R1 start", eng_start, 0);
  endtask

  task automatic t_map;
    logic [31:0] v;
    wr(4'd0, 32'hFFFF_FFFF); rd(4'd0, v); chk("R2 std clock mask", v, 32'hF3FF);
    chk("R2 std clock port", eng_clk_std, 16'hF3FF);
    wr(4'd1, 32'h1234_ABCD); rd(4'd1, v); chk("R2 hs clock mask", v, 32'hA3CD);
    wr(4'd2, 32'hFFFF_FFFF); rd(4'd2, v); chk("R2 cfg mask", v, 32'hFFF3);
    chk("R2 cfg port", eng_cfg, 16'hFFF3);
    wr(4'd4, 32'hFFFF_FFFF); rd(4'd4, v); chk("R2 slave", v, 32'h3FF);
    wr(4'd5, 32'hDEAD_BEEF); rd(4'd5, v); chk("R2 data low", v, 32'hDEAD_BEEF);
    wr(4'd6, 32'h0123_4567); rd(4'd6, v); chk("R2 data high", v, 32'h0123_4567);
    chk("R2 wdata port", eng_wdata, 64'h0123_4567_DEAD_BEEF);
  endtask

  task automatic t_launch;
    logic [31:0] v;
    wr(4'd3, 32'hFFFF_0273);
    chk("R3 start high", eng_start, 1);
    chk("R3 type", eng_type, 2);
    chk("R3 write len", eng_wr_len, 7);
    chk("R3 read len", eng_rd_len, 3);
    rd(4'd9, v); chk("R3 busy reads 1", v, 1);
    rd(4'd3, v); chk("R3 cmd readback", v, 32'h273);
    @(negedge clk);
    chk("R3 start single cycle", eng_start, 0);
  endtask

  task automatic t_busy_ignore;
    logic [31:0] v;
    wr(4'd3, 32'h0000_0100);
    chk("R4 no start", eng_start, 0);
    rd(4'd3, v); chk("R4 cmd kept", v, 32'h273);
    chk("R4 type kept", eng_type, 2);
  endtask

  task automatic t_done_capture;
    logic [31:0] v;
    done_pulse(4'b0000, 64'h1122_3344_5566_7788);
    rd(4'd9, v); chk("R5 busy cleared", v, 0);
    rd(4'd7, v); chk("R5 done bit", v, 32'h01);
    rd(4'd5, v); chk("R8 data low captured", v, 32'h5566_7788);
    rd(4'd6, v); chk("R8 data high captured", v, 32'h1122_3344);
    chk("R9 result ok", eng_result, 0);
    wr(4'd7, 32'h1F); rd(4'd7, v); chk("R6 clear all", v, 0);
  endtask

  task automatic t_write_only;
    logic [31:0] v;
    launch_and_finish(32'h0000_0070, 4'b0000, 64'hAAAA_BBBB_CCCC_DDDD);
    rd(4'd5, v); chk("R8 write-only keeps low", v, 32'h5566_7788);
    rd(4'd6, v); chk("R8 write-only keeps high", v, 32'h1122_3344);
    wr(4'd7, 32'h01);
  endtask

  task automatic t_errors;
    logic [31:0] v;
    launch_and_finish(32'h0, 4'b1110, 64'h0);
    rd(4'd7, v); chk("R5 error flags", v, 32'h1D);
    chk("R9 noresp outranks", eng_result, 2);
    wr(4'd7, 32'h05); rd(4'd7, v); chk("R6 partial clear", v, 32'h18);
    wr(4'd7, 32'h18); rd(4'd7, v); chk("R6 rest cleared", v, 0);
    launch_and_finish(32'h0, 4'b1111, 64'h0);
    rd(4'd7, v); chk("R5 all flags", v, 32'h1F);
    chk("R9 arb first", eng_result, 1);
    wr(4'd7, 32'h1F);
    launch_and_finish(32'h0, 4'b1100, 64'h0);
    chk("R9 collision over busy", eng_result, 3);
    wr(4'd7, 32'h1F);
    launch_and_finish(32'h0, 4'b1000, 64'h0);
    chk("R9 busy alone", eng_result, 4);
    wr(4'd7, 32'h1F);
    rd(4'd7, v); chk("R6 cleared after ranking", v, 0);
  endtask

  task automatic t_w1c_collide;
    logic [31:0] v;
    launch_and_finish(32'h0, 4'b0000, 64'h0);
    wr(4'd3, 32'h0);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 4'd7; bus_wdata = 32'h01;
    eng_done = 1'b1; eng_err = 4'b0000;
    @(negedge clk);
    bus_we = 1'b0; eng_done = 1'b0;
    rd(4'd7, v); chk("R6 set wins over clear", v, 32'h01);
    wr(4'd7, 32'h01);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    rd(4'd8, v); chk("R7 mask zero", v, 0);
    launch_and_finish(32'h0, 4'b0000, 64'h0);
    #1; chk("R7 masked off", irq, 0);
    wr(4'd8, 32'h01); #1; chk("R7 irq on mask", irq, 1);
    wr(4'd7, 32'h01); #1; chk("R7 irq clears", irq, 0);
    wr(4'd8, 32'h04);
    launch_and_finish(32'h0, 4'b0000, 64'h0);
    #1; chk("R7 done not enabled", irq, 0);
    wr(4'd7, 32'h1F);
    launch_and_finish(32'h0, 4'b0010, 64'h0);
    #1; chk("R7 noresp enabled", irq, 1);
    wr(4'd7, 32'h1F); wr(4'd8, 32'h0);
  endtask

  task automatic t_stray;
    logic [31:0] v;
    logic [31:0] lo;
    rd(4'd5, lo);
    done_pulse(4'b1111, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(4'd7, v); chk("R10 status unchanged", v, 0);
    rd(4'd5, v); chk("R10 data unchanged", v, lo);
    rd(4'd9, v); chk("R10 busy unchanged", v, 0);
    chk("R10 result unchanged", eng_result, 2);
  endtask

  initial begin
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    eng_done = 1'b0; eng_err = '0; eng_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_launch();
    t_busy_ignore();
    t_done_capture();
    t_write_only();
    t_errors();
    t_w1c_collide();
    t_irq();
    t_stray();
    if (!finished) begin
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule